// File: doc/BRIEF.md
# Conditioned Random Word Register Peripheral

This block sits behind a simple 32-bit register port. A sampled noise bit arrives on each qualified cycle. Each accepted bit is folded into a 32-bit linear-feedback accumulator. After every 32 accepted bits the accumulator value becomes one conditioned word. Up to four such words wait in a small queue. Software sees a ready flag and pops words through a data register.

Two fault inputs come from the analog side.

- A noise-source health fault halts generation and flushes the queue. It also latches a sticky flag. Software recovers by clearing that flag and then discarding a fixed run of twelve data reads. Only after that does fresh output appear.
- A clock-fault input is reported as a live state bit and a sticky flag. Software can mask it with a disable bit.

An interrupt line combines the ready flag and both sticky flags. It is gated by an enable bit.

Top module: `rng_regblock`

## Requirements
- R1: After reset the control register (offset 0x00) and the status register (offset 0x04) read 0, and `irq` is 0.
- R2: Control register: bit 2 enables generation, bit 3 enables the interrupt, bit 5 masks clock-fault detection. These bits read back as written and all other bits read 0. Status register: bit 0 is ready, bit 1 is the live clock fault, bit 2 is the live seed fault, bit 5 is the sticky clock flag and bit 6 is the sticky seed flag. All other status bits read 0.
- R3: While generation is enabled and no seed fault is active, each cycle with `ent_valid` high shifts in `ent_bit` as `a <= {a[30:0], a[31]^a[21]^a[1]^a[0]^ent_bit}`. The accumulator starts at 0x00000001 and returns to that value whenever generation is disabled. The value after every 32nd accepted bit is one word.
- R4: The queue holds 4 words. Ready (status bit 0) is 1 while at least one word is held. A word completed while the queue is full is dropped, and the accumulator keeps running.
- R5: A read of the data register (offset 0x08) while ready is 1 returns the oldest word and removes it. A read while ready is 0 returns 0 and removes nothing.
- R6: A `seed_fault` cycle while generation is enabled sets status bits 2 and 6 from the next cycle on. It also empties the queue and stops bit intake.
- R7: Writing the status register with bit 6 = 0 clears the seed flag, and writing bit 6 = 1 leaves it unchanged. After a clear that finds the seed fault active, the next 12 data reads return 0 and ready stays 0. The 12th of those reads clears status bit 2, and intake resumes.
- R8: With bit 5 of control at 0, status bit 1 equals `clk_fault` one cycle later, and status bit 5 latches it. Writing status bit 5 = 0 clears the flag, and writing 1 leaves it unchanged. With control bit 5 at 1, neither status bit is set.
- R9: A control write with bit 2 = 0 empties the queue, so ready is 0 from the next cycle. The sticky flags keep their values.
- R10: `irq` is 1 exactly when control bit 3 is 1 and at least one of status bits 0, 5 or 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read pops a word) |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| ent_bit | input | 1 | Sampled noise bit |
| ent_valid | input | 1 | Noise bit qualifier |
| seed_fault | input | 1 | Noise-source health fault |
| clk_fault | input | 1 | Clock fault indication |
| irq | output | 1 | Interrupt request |

## Verification
A wrong accumulator tap or bit count corrupts the first word popped after 32 accepted bits. The data read compares that word exactly. A queue pointer or count error shows up on the fifth word of a fill-and-drain run, or as a read that pops while ready is 0. A drain counter that is off by one clears the seed state one read early or late. The status check after the 11th and 12th discarded reads catches it within one read.

// File: rtl/rng_regblock_pkg.sv
package rng_regblock_pkg;
   localparam int CTRL_OFS = 0;
   localparam int STAT_OFS = 4;
   localparam int DATA_OFS = 8;
   localparam int CB_GEN   = 2;
   localparam int CB_IRQ   = 3;
   localparam int CB_CKOFF = 5;
   localparam int SB_RDY   = 0;
   localparam int SB_CKS   = 1;
   localparam int SB_SDS   = 2;
   localparam int SB_CKF   = 5;
   localparam int SB_SDF   = 6;

   typedef struct packed {
      logic ckoff;
      logic irq_en;
      logic gen_en;
   } ctrl_t;
endpackage

// File: rtl/rng_conditioner.sv
module rng_conditioner #(
   parameter int          W     = 32,
   parameter int          TAP   = 21,
   parameter logic [31:0] SEED  = 32'h1,
   parameter bit          MIX   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         take,
   input  logic         bit_in,
   output logic         word_valid,
   output logic [W-1:0] word
);
   localparam int CW = $clog2(W);

   if ((1 << CW) != W) begin : g_bad_w
      $error("rng_conditioner: W must be a power of two");
   end
   if (TAP >= W || TAP < 2) begin : g_bad_tap
      $error("rng_conditioner: TAP out of range");
   end

   logic [W-1:0]  acc, nxt;
   logic [CW-1:0] cnt;

   if (MIX) begin : g_mix
      assign nxt = {acc[W-2:0], acc[W-1] ^ acc[TAP] ^ acc[1] ^ acc[0] ^ bit_in};
   end else begin : g_plain
      assign nxt = {acc[W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= SEED[W-1:0];
         cnt <= '0;
      end else if (clear) begin
         acc <= SEED[W-1:0];
         cnt <= '0;
      end else if (take) begin
         acc <= nxt;
         cnt <= cnt + 1'b1;
      end
   end

   assign word_valid = take && !clear && (cnt == CW'(W - 1));
   assign word       = nxt;
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("rng_word_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= push_data;
   end

   assign head  = mem[rp];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> !full);
   p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
endmodule

// File: rtl/rng_seed_guard.sv
module rng_seed_guard #(
   parameter int DRAIN = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_in,
   input  logic gen_en,
   input  logic clr_wr,
   input  logic data_rd,
   output logic seed_state,
   output logic seed_flag,
   output logic draining
);
   localparam int DW = $clog2(DRAIN + 1);

   if (DRAIN < 1) begin : g_bad_drain
      $error("rng_seed_guard: DRAIN must be at least 1");
   end

   logic [DW-1:0] drain;
   logic          hit;

   assign hit = fault_in && gen_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_state <= 1'b0;
         seed_flag  <= 1'b0;
         drain      <= '0;
      end else if (hit) begin
         seed_state <= 1'b1;
         seed_flag  <= 1'b1;
         drain      <= '0;
      end else begin
         if (clr_wr) seed_flag <= 1'b0;
         if (clr_wr && seed_state && drain == '0) begin
            drain <= DW'(DRAIN);
         end else if (drain != '0 && data_rd) begin
            drain <= drain - 1'b1;
            if (drain == DW'(1)) seed_state <= 1'b0;
         end
      end
   end

   assign draining = (drain != '0);

   p_seed_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (seed_state && seed_flag));
   p_drain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drain != '0 && data_rd && !hit) |=> (drain == $past(drain) - 1'b1));
   p_state_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seed_state) |-> ($past(drain) == DW'(1)));
endmodule

// File: rtl/rng_regblock.sv
module rng_regblock
   import rng_regblock_pkg::*;
#(
   parameter int          ADDR_W = 4,
   parameter int          WORD_W = 32,
   parameter int          DEPTH  = 4,
   parameter int          DRAIN  = 12,
   parameter logic [31:0] SEED   = 32'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ent_bit,
   input  logic              ent_valid,
   input  logic              seed_fault,
   input  logic              clk_fault,
   output logic              irq
);
   if (WORD_W != 32) begin : g_bad_word
      $error("rng_regblock: register port carries 32-bit words");
   end

   ctrl_t       ctrl;
   logic        ck_state, ck_flag;
   logic        seed_state, seed_flag, draining;
   logic        sel_ctrl, sel_stat, sel_data;
   logic        ctrl_wr, stat_wr, data_rd;
   logic        ready, take, push, pop, flush, off_wr;
   logic        word_valid, f_empty, f_full;
   logic [31:0] word, head;
   logic        unused_wdata;

   assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
   assign sel_stat = (bus_addr == ADDR_W'(STAT_OFS));
   assign sel_data = (bus_addr == ADDR_W'(DATA_OFS));
   assign ctrl_wr  = bus_wr && sel_ctrl;
   assign stat_wr  = bus_wr && sel_stat;
   assign data_rd  = bus_rd && sel_data;
   assign off_wr   = ctrl_wr && !bus_wdata[CB_GEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_wr) begin
         ctrl.gen_en <= bus_wdata[CB_GEN];
         ctrl.irq_en <= bus_wdata[CB_IRQ];
         ctrl.ckoff  <= bus_wdata[CB_CKOFF];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_state <= 1'b0;
         ck_flag  <= 1'b0;
      end else begin
         ck_state <= clk_fault && !ctrl.ckoff;
         if (clk_fault && !ctrl.ckoff)          ck_flag <= 1'b1;
         else if (stat_wr && !bus_wdata[SB_CKF]) ck_flag <= 1'b0;
      end
   end

   assign take  = ent_valid && ctrl.gen_en && !seed_state;
   assign flush = !ctrl.gen_en || off_wr || (seed_fault && ctrl.gen_en);
   assign ready = !f_empty && !seed_state && !draining;
   assign push  = word_valid && !f_full;
   assign pop   = data_rd && ready;

   rng_conditioner #(.W(WORD_W), .TAP(21), .SEED(SEED), .MIX(1'b1)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (!ctrl.gen_en || off_wr),
      .take       (take),
      .bit_in     (ent_bit),
      .word_valid (word_valid),
      .word       (word)
   );

   rng_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (push),
      .push_data (word),
      .pop       (pop),
      .head      (head),
      .empty     (f_empty),
      .full      (f_full)
   );

   rng_seed_guard #(.DRAIN(DRAIN)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_in   (seed_fault),
      .gen_en     (ctrl.gen_en),
      .clr_wr     (stat_wr && !bus_wdata[SB_SDF]),
      .data_rd    (data_rd),
      .seed_state (seed_state),
      .seed_flag  (seed_flag),
      .draining   (draining)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctrl) begin
            bus_rdata[CB_GEN]   = ctrl.gen_en;
            bus_rdata[CB_IRQ]   = ctrl.irq_en;
            bus_rdata[CB_CKOFF] = ctrl.ckoff;
         end else if (sel_stat) begin
            bus_rdata[SB_RDY] = ready;
            bus_rdata[SB_CKS] = ck_state;
            bus_rdata[SB_SDS] = seed_state;
            bus_rdata[SB_CKF] = ck_flag;
            bus_rdata[SB_SDF] = seed_flag;
         end else if (sel_data && ready) begin
            bus_rdata = head;
         end
      end
   end

   assign irq = ctrl.irq_en && (ready || ck_flag || seed_flag);

   assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[4], bus_wdata[1:0]};

   p_disable_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      off_wr |=> !ready);
   p_ckflag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_flag && !(stat_wr && !bus_wdata[SB_CKF])) |=> ck_flag);
   p_seedflag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_flag && !(stat_wr && !bus_wdata[SB_SDF])) |=> seed_flag);
endmodule

// File: tb/rng_regblock_bench.sv
module rng_regblock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ent_bit = 1'b0, ent_valid = 1'b0;
   logic        seed_fault = 1'b0, clk_fault = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] mw = 32'h1;
   logic [31:0] pat = 32'h2545F491;
   logic [31:0] exp_w [8];

   always #5 clk = ~clk;

   rng_regblock u_rng_regblock (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ent_bit(ent_bit), .ent_valid(ent_valid), .seed_fault(seed_fault),
      .clk_fault(clk_fault), .irq(irq)
   );

   function automatic logic [31:0] mstep(input logic [31:0] w, input logic b);
      return {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0] ^ b};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic feed_word(output logic [31:0] w);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         ent_valid = 1'b1;
         ent_bit = pat[0];
         mw = mstep(mw, pat[0]);
         pat = pat ^ (pat << 13);
         pat = pat ^ (pat >> 17);
         pat = pat ^ (pat << 5);
      end
      @(negedge clk);
      ent_valid = 1'b0;
      w = mw;
   endtask

   task automatic pulse(input bit which);
      @(negedge clk);
      if (which) seed_fault = 1'b1; else clk_fault = 1'b1;
      @(negedge clk);
      seed_fault = 1'b0; clk_fault = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(4'h0, d); check("R1 ctrl after reset", d, 32'h0);
      rd(4'h4, d); check("R1 status after reset", d, 32'h0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R2 ctrl readback", d, 32'h0000_002C);
      wr(4'h0, 32'h0000_0004);
      rd(4'h0, d); check("R2 ctrl enable only", d, 32'h0000_0004);
      mw = 32'h1;
   endtask

   task automatic t_words();
      logic [31:0] d;
      feed_word(exp_w[0]);
      rd(4'h4, d); check("R4 ready after one word", d, 32'h1);
      feed_word(exp_w[1]);
      rd(4'h8, d); check("R3 first word", d, exp_w[0]);
      rd(4'h8, d); check("R5 second word in order", d, exp_w[1]);
      rd(4'h8, d); check("R5 empty read returns zero", d, 32'h0);
      rd(4'h4, d); check("R5 empty read pops nothing", d, 32'h0);
   endtask

   task automatic t_full();
      logic [31:0] d;
      for (int i = 0; i < 6; i++) feed_word(exp_w[i]);
      for (int i = 0; i < 4; i++) begin
         rd(4'h8, d); check("R4 fill and drain", d, exp_w[i]);
      end
      rd(4'h8, d); check("R4 words past full dropped", d, 32'h0);
      feed_word(exp_w[6]);
      rd(4'h8, d); check("R4 accumulator ran while full", d, exp_w[6]);
   endtask

   task automatic t_seed();
      logic [31:0] d;
      feed_word(exp_w[0]);
      feed_word(exp_w[1]);
      pulse(1'b1);
      rd(4'h4, d); check("R6 seed state and flag set", d, 32'h44);
      rd(4'h8, d); check("R6 queue flushed", d, 32'h0);
      wr(4'h4, 32'h40);
      rd(4'h4, d); check("R7 writing one keeps flag", d, 32'h44);
      wr(4'h4, 32'h0);
      rd(4'h4, d); check("R7 flag cleared", d, 32'h04);
      for (int i = 0; i < 11; i++) begin
         rd(4'h8, d); check("R7 discarded read", d, 32'h0);
      end
      rd(4'h4, d); check("R7 still draining after 11", d, 32'h04);
      rd(4'h8, d); check("R7 twelfth discarded read", d, 32'h0);
      rd(4'h4, d); check("R7 recovered after 12", d, 32'h0);
      feed_word(exp_w[2]);
      rd(4'h8, d); check("R7 generation resumed", d, exp_w[2]);
   endtask

   task automatic t_clk();
      logic [31:0] d;
      @(negedge clk); clk_fault = 1'b1;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'h4;
      #1 d = bus_rdata;
      clk_fault = 1'b0;
      @(negedge clk); bus_rd = 1'b0;
      check("R8 live and sticky clock bits", d, 32'h22);
      rd(4'h4, d); check("R8 live bit follows, flag sticks", d, 32'h20);
      wr(4'h4, 32'h20);
      rd(4'h4, d); check("R8 writing one keeps flag", d, 32'h20);
      wr(4'h4, 32'h0);
      rd(4'h4, d); check("R8 flag cleared", d, 32'h0);
      wr(4'h0, 32'h24);
      pulse(1'b0);
      rd(4'h4, d); check("R8 masked clock fault", d, 32'h0);
      wr(4'h0, 32'h04);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(4'h0, 32'h0C);
      check("R10 no cause, no irq", {31'b0, irq}, 32'h0);
      feed_word(exp_w[0]);
      check("R10 irq on ready", {31'b0, irq}, 32'h1);
      rd(4'h8, d); check("R5 word under irq", d, exp_w[0]);
      check("R10 irq drops when empty", {31'b0, irq}, 32'h0);
      pulse(1'b0);
      check("R10 irq on clock flag", {31'b0, irq}, 32'h1);
      wr(4'h0, 32'h04);
      check("R10 gated by enable", {31'b0, irq}, 32'h0);
      wr(4'h4, 32'h0);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      feed_word(exp_w[0]);
      pulse(1'b0);
      wr(4'h0, 32'h0);
      rd(4'h4, d); check("R9 ready dropped, flag kept", d, 32'h20);
      rd(4'h8, d); check("R9 queue flushed", d, 32'h0);
      wr(4'h0, 32'h04);
      mw = 32'h1;
      feed_word(exp_w[1]);
      rd(4'h8, d); check("R3 accumulator reseeded", d, exp_w[1]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_words();
      t_full();
      t_seed();
      t_clk();
      t_irq();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule